// File: doc/BRIEF.md
# Weighted Pending-Channel Service Selector

This block decides which of a set of interrupt channels gets serviced next. Channels raise requests through a set vector, and the block keeps them in a pending register. Each channel also has a current weight, loaded from a per-channel default. When asked to run a service round, the selector repeatedly presents the pending channel with the most weight left. It waits for the servicing agent to report completion, and then picks again.

Receive-type channels spend one unit of weight per service. Transmit-type channels do not. When channels are still pending but all of them have run out of weight, every weight is refilled from its default in a single step, and the search tries again.

Each round has a budget of actions. Both a selection and a refill count against it. If pending work remains when the budget runs out, the round stops with a one-cycle yield pulse, and the caller restarts it later with another request. A round that empties the pending register ends quietly. What the servicing agent does with the chosen channel is outside this block.

Top module: `wsel_arbiter`

## Requirements
- R1: With `rst_n` low at a clock edge (synchronous, active low), the pending register clears, the block goes idle with `sel_valid`, `yield` and `active` low, and every current weight loads from its field of `def_wt`. Channel i owns bits [i*WW +: WW] of `def_wt`.
- R2: A 1 on bit i of `pend_set` at a clock edge sets pending bit i, and `pend_q` shows the bit from the next cycle on. Set bits are ORed in and other bits are left alone.
- R3: A channel is eligible for selection only if its pending bit is 1 and its current weight is above zero.
- R4: The selected channel is the eligible channel with the largest current weight. When several channels share that weight, the lowest index wins.
- R5: On completion (`done` high while `sel_valid` is high), the served channel's weight drops by one if its `rx_kind` bit is 1. If its `rx_kind` bit is 0, the weight is unchanged. No other channel's weight changes.
- R6: On completion, the served channel's pending bit is cleared if `done_clr` is 1 and stays set if `done_clr` is 0.
- R7: When channels are pending but none is eligible, all weights reload from `def_wt` in one cycle and the selection is retried.
- R8: A request in idle loads a round budget of BUDGET actions. Each selection and each refill uses one action. If pending bits remain when the budget is zero, the round ends: `active` falls and `yield` is high for exactly one cycle. Weights and pending bits carry over to the next round.
- R9: A request with nothing pending, or a round whose pending register becomes empty, ends with `active` falling and `yield` staying low.
- R10: `sel_valid` stays high with `sel_idx` stable until `done` is seen, and `sel_idx` is always below NCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pend_set | input | NCH | Per-channel request set pulses |
| rx_kind | input | NCH | 1 marks a channel whose service spends weight |
| def_wt | input | NCH*WW | Default weight per channel |
| req | input | 1 | Start a service round (sampled while idle) |
| done | input | 1 | Service of the presented channel finished |
| done_clr | input | 1 | With `done`, clear the served channel's pending bit |
| sel_valid | output | 1 | A channel is presented for service |
| sel_idx | output | $clog2(NCH) | Index of the presented channel |
| yield | output | 1 | One-cycle pulse: round stopped on an exhausted budget |
| active | output | 1 | A round is in progress |
| pend_q | output | NCH | Current pending register |

## Verification
The bench builds the block with 20 channels, 4-bit weights and a budget of 8 instead of the default 100. The short budget makes budget exhaustion and the yield path reachable within a few selections. The defaults are set to index mod 5, so some channels can never become eligible. This makes rounds that only refill and then yield reachable. Even-numbered channels spend weight and odd-numbered channels do not, so both the refill path and the case where a transmit channel holds the lead are exercised.

// File: rtl/wsel_arbiter.sv
module wsel_arbiter #(
  parameter int NCH    = 20,
  parameter int WW     = 4,
  parameter int BUDGET = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          pend_set,
  input  logic [NCH-1:0]          rx_kind,
  input  logic [NCH*WW-1:0]       def_wt,
  input  logic                    req,
  input  logic                    done,
  input  logic                    done_clr,
  output logic                    sel_valid,
  output logic [$clog2(NCH)-1:0]  sel_idx,
  output logic                    yield,
  output logic                    active,
  output logic [NCH-1:0]          pend_q
);
  localparam int IW = $clog2(NCH);
  localparam int BW = $clog2(BUDGET + 1);

  typedef enum logic [1:0] {S_IDLE, S_PICK, S_WAIT} st_t;

  st_t            st;
  logic [BW-1:0]  cnt;
  logic [IW-1:0]  idx;
  logic [WW-1:0]  wt [NCH];
  logic [IW-1:0]  best;
  logic [WW-1:0]  best_w;
  logic           hit;
  logic [NCH-1:0] clr_mask;

  always_comb begin
    hit    = 1'b0;
    best   = '0;
    best_w = '0;
    for (int i = 0; i < NCH; i++) begin
      if (pend_q[i] && wt[i] > best_w) begin
        hit    = 1'b1;
        best   = IW'(i);
        best_w = wt[i];
      end
    end
  end

  always_comb begin
    clr_mask = '0;
    if (st == S_WAIT && done && done_clr) clr_mask[idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      idx    <= '0;
      yield  <= 1'b0;
      pend_q <= '0;
      for (int i = 0; i < NCH; i++) wt[i] <= def_wt[i*WW +: WW];
    end else begin
      yield  <= 1'b0;
      pend_q <= (pend_q & ~clr_mask) | pend_set;
      case (st)
        S_IDLE: if (req) begin
          cnt <= BW'(BUDGET);
          st  <= S_PICK;
        end
        S_PICK: begin
          if (pend_q == '0) begin
            st <= S_IDLE;
          end else if (cnt == '0) begin
            yield <= 1'b1;
            st    <= S_IDLE;
          end else if (hit) begin
            idx <= best;
            cnt <= cnt - BW'(1);
            st  <= S_WAIT;
          end else begin
            for (int i = 0; i < NCH; i++) wt[i] <= def_wt[i*WW +: WW];
            cnt <= cnt - BW'(1);
          end
        end
        S_WAIT: if (done) begin
          if (rx_kind[idx] && wt[idx] != '0) wt[idx] <= wt[idx] - WW'(1);
          st <= S_PICK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sel_valid = (st == S_WAIT);
  assign sel_idx   = idx;
  assign active    = (st != S_IDLE);
endmodule

// File: rtl/wsel_chk.sv
module wsel_chk #(
  parameter int NCH = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         pend_set,
  input logic                   done,
  input logic                   done_clr,
  input logic                   sel_valid,
  input logic [$clog2(NCH)-1:0] sel_idx,
  input logic                   yield,
  input logic                   active,
  input logic [NCH-1:0]         pend_q
);
  assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (32'(sel_idx) < NCH));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !done) |=> (sel_valid && $stable(sel_idx)));

  assert_sel_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_valid) |-> pend_q[sel_idx]);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && done && done_clr && !pend_set[sel_idx]) |=> !pend_q[$past(sel_idx)]);

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && done && !done_clr) |=> pend_q[$past(sel_idx)]);

  assert_yield_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    yield |-> !active);

  assert_yield_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    yield |=> !yield);
endmodule

bind wsel_arbiter wsel_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .done(done), .done_clr(done_clr),
  .sel_valid(sel_valid), .sel_idx(sel_idx), .yield(yield), .active(active), .pend_q(pend_q)
);

// File: tb/tb_wsel_arbiter.sv
module tb_wsel_arbiter;
  localparam int NCH = 20;
  localparam int WW  = 4;
  localparam int BUD = 8;
  localparam int IW  = $clog2(NCH);
  localparam int C_END   = -1;
  localparam int C_YIELD = -2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] pend_set = '0;
  logic [NCH-1:0] rx_kind;
  logic [NCH*WW-1:0] def_wt;
  logic req = 1'b0;
  logic done = 1'b0;
  logic done_clr = 1'b0;
  logic sel_valid, yield, active;
  logic [IW-1:0] sel_idx;
  logic [NCH-1:0] pend_q;

  wsel_arbiter #(.NCH(NCH), .WW(WW), .BUDGET(BUD)) dut (
    .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .rx_kind(rx_kind), .def_wt(def_wt),
    .req(req), .done(done), .done_clr(done_clr), .sel_valid(sel_valid), .sel_idx(sel_idx),
    .yield(yield), .active(active), .pend_q(pend_q)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  bit clr_q[$];
  logic [NCH-1:0] m_pend;
  int m_wt [NCH];

  function automatic int dflt(int i);
    return i % 5;
  endfunction

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_pend = '0;
    for (int i = 0; i < NCH; i++) m_wt[i] = dflt(i);
  endtask

  task automatic set_pend(logic [NCH-1:0] m);
    @(negedge clk);
    pend_set = m;
    @(negedge clk);
    pend_set = '0;
    m_pend |= m;
    chk("R2 pend_q after set", int'(pend_q), int'(m_pend));
  endtask

  // mode 0: always clear, 1: never clear, 2: alternate starting with clear
  task automatic run_round(int mode);
    int budget = BUD;
    bit alt = 1'b1;
    forever begin
      int best = -1;
      int bw = 0;
      if (m_pend == '0) begin exp_q.push_back(C_END); break; end
      if (budget == 0) begin exp_q.push_back(C_YIELD); break; end
      for (int i = 0; i < NCH; i++)
        if (m_pend[i] && m_wt[i] > bw) begin best = i; bw = m_wt[i]; end
      budget--;
      if (best >= 0) begin
        bit c = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : alt;
        alt = ~alt;
        exp_q.push_back(best);
        clr_q.push_back(c);
        if (rx_kind[best] && m_wt[best] > 0) m_wt[best]--;
        if (c) m_pend[best] = 1'b0;
      end else begin
        for (int i = 0; i < NCH; i++) m_wt[i] = dflt(i);
      end
    end
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R6 pending after round", int'(pend_q), int'(m_pend));
  endtask

  initial begin : monitor
    bit pv = 1'b0;
    bit pa = 1'b0;
    forever begin
      @(negedge clk);
      if (done) begin
        done = 1'b0;
        done_clr = 1'b0;
      end else if (sel_valid && !pv) begin
        if (exp_q.size() == 0) chk("R4 unexpected selection", int'(sel_idx), -99);
        else begin
          chk("R4 R3 R5 R7 selected index", int'(sel_idx), exp_q.pop_front());
          done = 1'b1;
          done_clr = clr_q.pop_front();
        end
      end
      if (pa && !active) begin
        if (exp_q.size() == 0) chk("R9 unexpected round end", int'(yield), -99);
        else chk("R8 R9 round end kind", yield ? C_YIELD : C_END, exp_q.pop_front());
      end
      pv = sel_valid;
      pa = active;
    end
  end

  initial begin : watchdog
    #1ms;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin
      def_wt[i*WW +: WW] = WW'(dflt(i));
      rx_kind[i] = (i % 2 == 0);
    end
    do_reset();
    chk("R1 reset pend_q", int'(pend_q), 0);
    chk("R1 reset sel_valid", int'(sel_valid), 0);
    chk("R1 reset yield", int'(yield), 0);
    chk("R1 reset active", int'(active), 0);

    run_round(0);                          // R9 empty request
    set_pend(20'h02108);                   // channels 3, 8, 13 tie at weight 3
    run_round(0);                          // R4 tie order
    set_pend(20'h84210);                   // 4, 9, 14, 19 at weight 4
    run_round(1);                          // R5 tx keeps weight, R8 yield
    run_round(0);
    run_round(0);

    do_reset();
    set_pend(20'h00004);                   // channel 2, rx, weight 2
    run_round(1);                          // R7 refill inside round

    do_reset();
    set_pend(20'h08421);                   // zero-weight channels only
    run_round(0);                          // R7 refills then R8 yield

    do_reset();
    set_pend(20'hDEF7B);
    for (int k = 0; k < 6; k++) run_round(2);
    set_pend(20'h31CE6);
    for (int k = 0; k < 6; k++) run_round(k % 3);
    for (int k = 0; k < 6; k++) run_round(0);
    summary();
  end
endmodule